// File: doc/BRIEF.md
# DMA Page Address Extender

This block builds the 32-bit physical bus address of one DMA channel. It joins the 16-bit current address of the channel's address counter with two 8-bit page registers: a low page and a high page. The block does not count addresses itself. It watches the counter's increment strobe and carry-out, and it takes byte-wide port writes that load the two page registers or clear its error flag. A parameter selects a byte-wide channel or a word-wide channel. On a word-wide channel the counter value is a word address and is shifted up one bit, and the lowest bit of the low page is not used.

A two-state mode machine decides what happens when the counter wraps. In `MODE_LEGACY`, which the block enters at reset, the page registers never move. The address then wraps inside its 64 KB window (byte channel) or 128 KB window (word channel). A wrap while a transfer is still running sets a sticky `bound_err` flag. Writing the high page takes the machine from `MODE_LEGACY` to `MODE_EXTENDED`. In that mode every counter carry adds one to the joined {high page, low page} field, at bit 0 for byte channels and at bit 1 for word channels, so a transfer can run past the window edge. Writing the low page takes the machine back from `MODE_EXTENDED` to `MODE_LEGACY`. Software must therefore write the high page last when it sets up a channel.

Top module: `dma_page_ext`

## Requirements
- R1: After reset both page registers are zero, the mode is legacy and `bound_err` is 0. The bus address then equals `cur_addr` on a byte channel and `{cur_addr,1'b0}` on a word channel.
- R2: On a byte channel, `bus_addr[15:0]` is `cur_addr` and `bus_addr[23:16]` is the low page register.
- R3: On a word channel, `bus_addr[0]` is 0, `bus_addr[16:1]` is `cur_addr` and `bus_addr[23:17]` is low page bits [7:1]. Low page bit 0 has no effect on the address.
- R4: `bus_addr[31:24]` is the high page register on both channel kinds.
- R5: A write with `wr_sel`=1 loads the high page and enters extended mode. A write with `wr_sel`=0 loads the low page and returns to legacy mode. The high page value is kept.
- R6: In legacy mode, a cycle with `addr_step` and `addr_carry` both high leaves both page registers unchanged.
- R7: In extended mode, a cycle with `addr_step` and `addr_carry` both high adds one (byte channel) or two (word channel) to the 16-bit {high, low} page field, and the new value appears in the next cycle. A carry out of the low page enters the high page. `addr_carry` without `addr_step` changes nothing.
- R8: In legacy mode, a cycle with `addr_step`, `addr_carry` and `xfer_busy` all high sets `bound_err` from the next cycle on. The flag stays set until it is cleared.
- R9: A wrap with `xfer_busy` low, or any wrap in extended mode, does not set `bound_err`.
- R10: A write with `wr_sel`=2 clears `bound_err`. If a setting wrap happens in the same cycle, the flag stays set.
- R11: A page write in the same cycle as a carry step loads the written value, and no increment is applied. The mode used for that carry step is the mode before the write.
- R12: A write with `wr_sel`=3 changes neither the page registers, the mode nor `bound_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_addr | input | 16 | Current address from the channel counter |
| addr_step | input | 1 | Counter advances this cycle |
| addr_carry | input | 1 | Counter wraps out of its top bit on this step |
| xfer_busy | input | 1 | Transfer still has items left to move |
| wr_en | input | 1 | Port write strobe |
| wr_sel | input | 2 | Write target: 0 low page, 1 high page, 2 clear flag, 3 none |
| wr_data | input | 8 | Port write data |
| bus_addr | output | 32 | Physical bus address |
| bound_err | output | 1 | Sticky legacy window-crossing flag |

## Verification
The hardest cases to reach are the cycles where a port write meets a counter carry. These are a low-page write during an extended-mode carry, a flag clear during a setting wrap, and a high-page write during a legacy wrap. In each case the mode, the page field and the flag each follow a different priority. The vector table places both events in the same driven cycle. It then reads the result one edge later through `bus_addr` and `bound_err`. A carry from 0x12FF into the high page is reached by loading the low page with 0xFF first. The word channel is checked after an in-run reset, so that its page-field step of two starts from known values.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

    typedef enum logic [1:0] {
        SEL_PAGE    = 2'd0,
        SEL_HIPAGE  = 2'd1,
        SEL_CLRFLAG = 2'd2,
        SEL_NONE    = 2'd3
    } wsel_e;

    typedef enum logic {
        MODE_LEGACY   = 1'b0,
        MODE_EXTENDED = 1'b1
    } mode_e;

endpackage

// File: rtl/dpx_page_regs.sv
module dpx_page_regs
    import dpx_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter bit WORD_CHAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [PAGE_W-1:0] wr_data,
    input  logic              step_carry,
    output logic [PAGE_W-1:0] page_q,
    output logic [PAGE_W-1:0] hipage_q,
    output logic              ext_mode
);
    localparam int SEG_W = 2 * PAGE_W;
    localparam logic [SEG_W-1:0] SEG_INC = WORD_CHAN ? SEG_W'(2) : SEG_W'(1);

    mode_e            mode_q, mode_d;
    logic [SEG_W-1:0] seg_q, seg_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_LEGACY;
        else        mode_q <= mode_d;
    end

    // transitions
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_LEGACY:   if (wr_en && wr_sel == SEL_HIPAGE) mode_d = MODE_EXTENDED;
            MODE_EXTENDED: if (wr_en && wr_sel == SEL_PAGE)   mode_d = MODE_LEGACY;
            default:       mode_d = MODE_LEGACY;
        endcase
    end

    // page field: port write first, then extended-mode carry
    always_comb begin
        seg_d = seg_q;
        if (wr_en && wr_sel == SEL_PAGE)
            seg_d[PAGE_W-1:0] = wr_data;
        else if (wr_en && wr_sel == SEL_HIPAGE)
            seg_d[SEG_W-1:PAGE_W] = wr_data;
        else if (mode_q == MODE_EXTENDED && step_carry)
            seg_d = seg_q + SEG_INC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seg_q <= '0;
        else        seg_q <= seg_d;
    end

    // outputs
    always_comb begin
        page_q   = seg_q[PAGE_W-1:0];
        hipage_q = seg_q[SEG_W-1:PAGE_W];
        ext_mode = (mode_q == MODE_EXTENDED);
    end
endmodule

// File: rtl/dpx_addr_map.sv
module dpx_addr_map #(
    parameter int CNT_W     = 16,
    parameter int PAGE_W    = 8,
    parameter bit WORD_CHAN = 1'b0
) (
    input  logic [CNT_W-1:0]            cur_addr,
    input  logic [PAGE_W-1:0]           page_q,
    input  logic [PAGE_W-1:0]           hipage_q,
    output logic [2*PAGE_W+CNT_W-1:0]   bus_addr
);
    generate
        if (WORD_CHAN) begin : g_word
            // page bit 0 dropped, counter counts words
            assign bus_addr = {hipage_q, page_q[PAGE_W-1:1], cur_addr, 1'b0};
        end else begin : g_byte
            assign bus_addr = {hipage_q, page_q, cur_addr};
        end
    endgenerate
endmodule

// File: rtl/dpx_bound_flag.sv
module dpx_bound_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode,
    input  logic step_carry,
    input  logic xfer_busy,
    input  logic clr,
    output logic flag_q
);
    logic set_ev;

    always_comb set_ev = !ext_mode && step_carry && xfer_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_ev) flag_q <= 1'b1;
        else if (clr)    flag_q <= 1'b0;
    end
endmodule

// File: rtl/dma_page_ext.sv
module dma_page_ext
    import dpx_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PAGE_W    = 8,
    parameter bit WORD_CHAN = 1'b0,
    localparam int ADDR_W   = 2 * PAGE_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cur_addr,
    input  logic              addr_step,
    input  logic              addr_carry,
    input  logic              xfer_busy,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [PAGE_W-1:0] wr_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bound_err
);
    logic              step_carry;
    logic              flag_clr;
    logic              ext_mode;
    logic [PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0] hipage_q;

    always_comb begin
        step_carry = addr_step && addr_carry;
        flag_clr   = wr_en && (wr_sel == SEL_CLRFLAG);
    end

    dpx_page_regs #(.PAGE_W(PAGE_W), .WORD_CHAN(WORD_CHAN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .step_carry (step_carry),
        .page_q     (page_q),
        .hipage_q   (hipage_q),
        .ext_mode   (ext_mode)
    );

    dpx_addr_map #(.CNT_W(CNT_W), .PAGE_W(PAGE_W), .WORD_CHAN(WORD_CHAN)) u_map (
        .cur_addr (cur_addr),
        .page_q   (page_q),
        .hipage_q (hipage_q),
        .bus_addr (bus_addr)
    );

    dpx_bound_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_mode   (ext_mode),
        .step_carry (step_carry),
        .xfer_busy  (xfer_busy),
        .clr        (flag_clr),
        .flag_q     (bound_err)
    );
endmodule

// File: rtl/dma_page_ext_chk.sv
module dma_page_ext_chk #(
    parameter int PAGE_W    = 8,
    parameter bit WORD_CHAN = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic              addr_step,
    input logic              addr_carry,
    input logic              xfer_busy,
    input logic              ext_mode,
    input logic [PAGE_W-1:0] page_q,
    input logic [PAGE_W-1:0] hipage_q,
    input logic              bound_err
);
    localparam int SEG_W = 2 * PAGE_W;
    localparam logic [SEG_W-1:0] STEP_V = WORD_CHAN ? SEG_W'(2) : SEG_W'(1);

    logic [SEG_W-1:0] seg;
    logic             wrap, set_cond;
    always_comb begin
        seg      = {hipage_q, page_q};
        wrap     = addr_step && addr_carry;
        set_cond = !ext_mode && wrap && xfer_busy;
    end

    AST_LEGACY_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && wrap && !wr_en) |=> $stable(seg)); // R6
    AST_EXT_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && wrap && !wr_en) |=> (seg == $past(seg) + STEP_V)); // R7
    AST_HIPAGE_ENTERS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> ext_mode); // R5
    AST_PAGE_LEAVES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> !ext_mode); // R5
    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        set_cond |=> bound_err); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (bound_err && !(wr_en && wr_sel == 2'd2)) |=> bound_err); // R8
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && !set_cond) |=> !bound_err); // R10
    AST_RSVD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3 && !wrap) |=> ($stable(seg) && $stable(ext_mode))); // R12
endmodule

bind dma_page_ext dma_page_ext_chk #(.PAGE_W(PAGE_W), .WORD_CHAN(WORD_CHAN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .addr_step  (addr_step),
    .addr_carry (addr_carry),
    .xfer_busy  (xfer_busy),
    .ext_mode   (ext_mode),
    .page_q     (page_q),
    .hipage_q   (hipage_q),
    .bound_err  (bound_err)
);

// File: tb/sim_dma_page_ext.sv
module sim_dma_page_ext;
    localparam int CLK_T    = 10;
    localparam int WD_LIMIT = 5000;

    typedef struct packed {
        logic        we;
        logic [1:0]  sel;
        logic [7:0]  d;
        logic [15:0] cur;
        logic        stp;
        logic        cy;
        logic        busy;
        logic [31:0] ea;
        logic        ee;
    } vec_t;

    localparam int NV = 17;
    // byte channel walk starting from reset state
    localparam vec_t VT [NV] = '{
        '{1'b0, 2'd0, 8'h00, 16'h1234, 1'b0, 1'b0, 1'b0, 32'h0000_1234, 1'b0}, // R1 R2
        '{1'b1, 2'd0, 8'h5A, 16'hABCD, 1'b0, 1'b0, 1'b0, 32'h005A_ABCD, 1'b0}, // R2
        '{1'b1, 2'd1, 8'h12, 16'h0010, 1'b0, 1'b0, 1'b0, 32'h125A_0010, 1'b0}, // R4 R5
        '{1'b0, 2'd0, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b1, 32'h125B_0000, 1'b0}, // R7 R9
        '{1'b0, 2'd0, 8'h00, 16'h0001, 1'b1, 1'b0, 1'b1, 32'h125B_0001, 1'b0}, // R7
        '{1'b1, 2'd0, 8'hFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 32'h12FF_FFFF, 1'b0}, // R5
        '{1'b0, 2'd0, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b1, 32'h12FF_0000, 1'b1}, // R6 R8
        '{1'b0, 2'd0, 8'h00, 16'h0005, 1'b0, 1'b0, 1'b0, 32'h12FF_0005, 1'b1}, // R8
        '{1'b1, 2'd3, 8'h77, 16'h0005, 1'b0, 1'b0, 1'b0, 32'h12FF_0005, 1'b1}, // R12
        '{1'b1, 2'd2, 8'h00, 16'h0005, 1'b0, 1'b0, 1'b0, 32'h12FF_0005, 1'b0}, // R10
        '{1'b0, 2'd0, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b0, 32'h12FF_0000, 1'b0}, // R9
        '{1'b1, 2'd1, 8'h12, 16'hFFFF, 1'b0, 1'b0, 1'b0, 32'h12FF_FFFF, 1'b0}, // R5
        '{1'b0, 2'd0, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b1, 32'h1300_0000, 1'b0}, // R7
        '{1'b1, 2'd0, 8'h40, 16'h0000, 1'b1, 1'b1, 1'b1, 32'h1340_0000, 1'b0}, // R11
        '{1'b1, 2'd2, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b1, 32'h1340_0000, 1'b1}, // R10
        '{1'b1, 2'd2, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 32'h1340_0000, 1'b0}, // R10
        '{1'b1, 2'd1, 8'h80, 16'h0000, 1'b1, 1'b1, 1'b1, 32'h8040_0000, 1'b1}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cur_addr = '0;
    logic        addr_step = 1'b0, addr_carry = 1'b0, xfer_busy = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = '0;
    logic [31:0] bus_b, bus_w;
    logic        err_b, err_w;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_T / 2) clk = ~clk;

    dma_page_ext #(.WORD_CHAN(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cur_addr(cur_addr), .addr_step(addr_step),
        .addr_carry(addr_carry), .xfer_busy(xfer_busy), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .bus_addr(bus_b), .bound_err(err_b));

    dma_page_ext #(.WORD_CHAN(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cur_addr(cur_addr), .addr_step(addr_step),
        .addr_carry(addr_carry), .xfer_busy(xfer_busy), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .bus_addr(bus_w), .bound_err(err_w));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // drive at falling edge, hold across one rising edge, sample a quarter period later
    task automatic drive(input logic we, input logic [1:0] sel, input logic [7:0] d,
                         input logic [15:0] cur, input logic stp, input logic cy,
                         input logic busy);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; cur_addr = cur;
        addr_step = stp; addr_carry = cy; xfer_busy = busy;
        @(posedge clk);
        #(CLK_T / 4);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        cur_addr = 16'h00C3;
        #(CLK_T / 4);
        chk("R1 byte reset addr", bus_b, 32'h0000_00C3);
        chk("R1 word reset addr", bus_w, 32'h0000_0186);
        chk("R1 reset flag", {31'd0, err_b}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VT[i].we, VT[i].sel, VT[i].d, VT[i].cur, VT[i].stp, VT[i].cy, VT[i].busy);
            chk($sformatf("vector %0d addr", i), bus_b, VT[i].ea);
            chk($sformatf("vector %0d flag", i), {31'd0, err_b}, {31'd0, VT[i].ee});
        end

        // R1: reset in the middle of a run
        @(negedge clk);
        wr_en = 1'b0; addr_step = 1'b0; addr_carry = 1'b0; xfer_busy = 1'b0;
        cur_addr = 16'hBEEF; rst_n = 1'b0;
        #(CLK_T / 4);
        chk("R1 in-run reset addr", bus_b, 32'h0000_BEEF);
        chk("R1 in-run reset flag", {31'd0, err_b}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // word channel corner cases
        drive(1'b1, 2'd0, 8'h35, 16'h8001, 1'b0, 1'b0, 1'b0);
        chk("R3 word map, page bit0 ignored", bus_w, 32'h0035_0002);
        chk("R2 byte map same page", bus_b, 32'h0035_8001);
        drive(1'b1, 2'd1, 8'h01, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        chk("R4 word high page", bus_w, 32'h0135_FFFE);
        drive(1'b0, 2'd0, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b1);
        chk("R7 word carry adds two", bus_w, 32'h0136_0000);
        chk("R9 word ext wrap no flag", {31'd0, err_w}, 32'd0);
        drive(1'b1, 2'd0, 8'h35, 16'h0000, 1'b0, 1'b0, 1'b0);
        chk("R5 word back to legacy", bus_w, 32'h0134_0000);
        drive(1'b0, 2'd0, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b1);
        chk("R6 word legacy page held", bus_w, 32'h0134_0000);
        chk("R8 word legacy wrap flag", {31'd0, err_w}, 32'd1);

        @(negedge clk);
        addr_step = 1'b0; addr_carry = 1'b0;
        finish_run();
    end
endmodule